// File: doc/BRIEF.md
# Dual-Modulus Feedback and Reference Divider

This block provides the two frequency dividers that feed a phase detector in a frequency synthesizer. The feedback path divides the oscillator clock with a prescaler that has two moduli, a long one (7) and a short one (6). A pulse-swallow counter picks the modulus for each prescaler period, and a main counter counts the prescaler periods in each feedback frame. A double-rate bit turns the two moduli into 14 and 12. The reference path is a plain programmable divider on the reference clock. Each path emits a one-cycle pulse at the end of each of its frames.

Software writes the divider fields at any time. Each path copies its fields only at its own frame boundary. A frame that is already running therefore always finishes with the setting it started with. The two paths run in their own clock domains and share only the asynchronous reset.

Top module: `fbdiv_top`

## Requirements
- R1: While `rst_n` is low, `fb_pulse` and `ref_pulse` are both 0.
- R2: A feedback frame spans `cfg_m`+1 prescaler periods. The main counter steps down once per prescaler period and holds between them.
- R3: With `cfg_a` = 0, every prescaler period is long. Consecutive `fb_pulse` assertions are 7·(`cfg_m`+1) oscillator cycles apart.
- R4: With 1 ≤ `cfg_a` ≤ `cfg_m`+1, the first `cfg_a` periods of a frame are long and the rest are short. The spacing is 6·(`cfg_m`+1)+`cfg_a` cycles.
- R5: With `cfg_a` > `cfg_m`+1, every period is long. The spacing is 7·(`cfg_m`+1).
- R6: With `cfg_dbl` = 1, the long and short moduli become 14 and 12. The spacing doubles compared with `cfg_dbl` = 0.
- R7: `fb_pulse` is high for exactly one oscillator cycle per frame. It is asserted only at the end of a prescaler period.
- R8: `cfg_m`, `cfg_a` and `cfg_dbl` are sampled only at the clock edge that ends a feedback frame, or at the first edge after reset. A change made during a frame leaves that frame's length unchanged.
- R9: `ref_pulse` assertions are `cfg_r`+1 reference cycles apart. Each pulse is one cycle wide when `cfg_r` > 0. When `cfg_r` = 0, `ref_pulse` stays high.
- R10: `cfg_r` is sampled only at the edge that ends a reference frame. A change made during a frame leaves that frame's length unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_vco | input | 1 | Oscillator clock, feedback path |
| clk_ref | input | 1 | Reference clock, reference path |
| rst_n | input | 1 | Asynchronous active-low reset, both domains |
| cfg_m | input | 6 | Main counter field; frame = value+1 prescaler periods |
| cfg_a | input | 4 | Swallow count; number of long periods per frame |
| cfg_dbl | input | 1 | 1 doubles the prescaler moduli to 14/12 |
| cfg_r | input | 7 | Reference divider field; modulus = value+1 |
| fb_pulse | output | 1 | One-cycle pulse at the end of each feedback frame |
| ref_pulse | output | 1 | One-cycle pulse at the end of each reference frame |

## Verification
The feedback spacing is measured for each of the three swallow regimes: A zero, A within the frame, and A beyond the frame. The boundary case A = M+1 must give the same spacing as all-long. The smallest and largest M values are tested, and a seeded random sweep covers both prescaler rates. Each random case is tagged with the regime it falls into, so a wrong short modulus, an off-by-one in the swallow count and a missing doubling each show up as a different spacing. Mid-frame writes to both dividers check that the current frame keeps its length and that the new value appears one frame later. A reference field of zero checks the continuous-high case.

// File: rtl/fbdiv_pkg.sv
package fbdiv_pkg;

  typedef enum logic {
    PH_LOAD = 1'b0,
    PH_RUN  = 1'b1
  } phase_e;

  // Length of one prescaler period for a given selection.
  function automatic int psc_len(input bit use_long, input bit dbl,
                                 input int long_mod, input int short_mod);
    int base;
    base = use_long ? long_mod : short_mod;
    return dbl ? 2 * base : base;
  endfunction

  // Total feedback division ratio for a field setting.
  function automatic int fb_ratio(input int m, input int a, input bit dbl,
                                  input int long_mod, input int short_mod);
    int periods;
    int base;
    periods = m + 1;
    if (a == 0 || a > periods)
      base = long_mod * periods;
    else
      base = short_mod * periods + a * (long_mod - short_mod);
    return dbl ? 2 * base : base;
  endfunction

endpackage

// File: rtl/fbdiv_prescaler.sv
module fbdiv_prescaler
  import fbdiv_pkg::*;
#(
  parameter int LONG_MOD  = 7,
  parameter int SHORT_MOD = 6,
  parameter bit DBL_EN    = 1'b1,
  parameter int P_W       = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           active,
  input  logic           reload,
  input  logic           nxt_long,
  input  logic           nxt_dbl,
  output logic [P_W-1:0] cnt,
  output logic           tc
);

  logic dbl_eff;

  generate
    if (DBL_EN) begin : g_dbl
      assign dbl_eff = nxt_dbl;
    end else begin : g_single
      assign dbl_eff = 1'b0;
    end
  endgenerate

  logic [P_W-1:0] load_val;
  assign load_val = P_W'(psc_len(nxt_long, dbl_eff, LONG_MOD, SHORT_MOD) - 1);

  // End of the current prescaler period.
  assign tc = active && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt <= '0;
    else if (reload)
      cnt <= load_val;
    else if (active)
      cnt <= cnt - 1'b1;
  end

endmodule

// File: rtl/fbdiv_mctl.sv
module fbdiv_mctl
  import fbdiv_pkg::*;
#(
  parameter int M_W = 6,
  parameter int A_W = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [M_W-1:0] cfg_m,
  input  logic [A_W-1:0] cfg_a,
  input  logic           cfg_dbl,
  input  logic           psc_tc,
  output logic           run,
  output logic           frame_end,
  output logic [M_W-1:0] mcnt,
  output logic [A_W-1:0] acnt,
  output logic           reload,
  output logic           nxt_long,
  output logic           nxt_dbl
);

  phase_e         phase;
  logic           azero_sh;
  logic           dbl_sh;
  logic [A_W-1:0] acnt_dec;
  logic           take_cfg;

  assign run       = (phase == PH_RUN);
  assign frame_end = run && psc_tc && (mcnt == '0);
  assign take_cfg  = !run || frame_end;
  assign reload    = take_cfg || psc_tc;

  // Swallow count after the current long period completes.
  assign acnt_dec = (acnt != '0) ? acnt - 1'b1 : '0;

  // The first period of a frame is always long. Later periods are long
  // while swallow counts remain, or always when the swallow field is zero.
  always_comb begin
    if (take_cfg) begin
      nxt_long = 1'b1;
      nxt_dbl  = cfg_dbl;
    end else begin
      nxt_long = azero_sh || (acnt_dec != '0);
      nxt_dbl  = dbl_sh;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= PH_LOAD;
      mcnt     <= '0;
      acnt     <= '0;
      azero_sh <= 1'b1;
      dbl_sh   <= 1'b0;
    end else if (take_cfg) begin
      phase    <= PH_RUN;
      mcnt     <= cfg_m;
      acnt     <= cfg_a;
      azero_sh <= (cfg_a == '0);
      dbl_sh   <= cfg_dbl;
    end else if (psc_tc) begin
      mcnt <= mcnt - 1'b1;
      acnt <= acnt_dec;
    end
  end

endmodule

// File: rtl/fbdiv_refdiv.sv
module fbdiv_refdiv
  import fbdiv_pkg::*;
#(
  parameter int R_W = 7
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [R_W-1:0] cfg_r,
  output logic           run,
  output logic [R_W-1:0] cnt,
  output logic           pulse
);

  phase_e phase;

  assign run   = (phase == PH_RUN);
  assign pulse = run && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_LOAD;
      cnt   <= '0;
    end else if (!run || pulse) begin
      phase <= PH_RUN;
      cnt   <= cfg_r;
    end else begin
      cnt <= cnt - 1'b1;
    end
  end

endmodule

// File: rtl/fbdiv_top.sv
module fbdiv_top
  import fbdiv_pkg::*;
#(
  parameter int M_W       = 6,
  parameter int A_W       = 4,
  parameter int R_W       = 7,
  parameter int LONG_MOD  = 7,
  parameter int SHORT_MOD = 6,
  parameter bit DBL_EN    = 1'b1
) (
  input  logic           clk_vco,
  input  logic           clk_ref,
  input  logic           rst_n,
  input  logic [M_W-1:0] cfg_m,
  input  logic [A_W-1:0] cfg_a,
  input  logic           cfg_dbl,
  input  logic [R_W-1:0] cfg_r,
  output logic           fb_pulse,
  output logic           ref_pulse
);

  localparam int P_W = $clog2(2 * LONG_MOD);

  // Internal events, named for the checker.
  logic           fb_run;
  logic           frame_end;
  logic           psc_tc;
  logic           psc_reload;
  logic           nxt_long;
  logic           nxt_dbl;
  logic [P_W-1:0] psc_cnt;
  logic [M_W-1:0] mcnt;
  logic [A_W-1:0] acnt;
  logic           ref_run;
  logic [R_W-1:0] ref_cnt;

  fbdiv_mctl #(.M_W(M_W), .A_W(A_W)) u_mctl (
    .clk       (clk_vco),
    .rst_n     (rst_n),
    .cfg_m     (cfg_m),
    .cfg_a     (cfg_a),
    .cfg_dbl   (cfg_dbl),
    .psc_tc    (psc_tc),
    .run       (fb_run),
    .frame_end (frame_end),
    .mcnt      (mcnt),
    .acnt      (acnt),
    .reload    (psc_reload),
    .nxt_long  (nxt_long),
    .nxt_dbl   (nxt_dbl)
  );

  fbdiv_prescaler #(
    .LONG_MOD (LONG_MOD),
    .SHORT_MOD(SHORT_MOD),
    .DBL_EN   (DBL_EN),
    .P_W      (P_W)
  ) u_psc (
    .clk     (clk_vco),
    .rst_n   (rst_n),
    .active  (fb_run),
    .reload  (psc_reload),
    .nxt_long(nxt_long),
    .nxt_dbl (nxt_dbl),
    .cnt     (psc_cnt),
    .tc      (psc_tc)
  );

  fbdiv_refdiv #(.R_W(R_W)) u_ref (
    .clk  (clk_ref),
    .rst_n(rst_n),
    .cfg_r(cfg_r),
    .run  (ref_run),
    .cnt  (ref_cnt),
    .pulse(ref_pulse)
  );

  assign fb_pulse = frame_end;

endmodule

// File: rtl/fbdiv_checker.sv
module fbdiv_checker #(
  parameter int M_W      = 6,
  parameter int R_W      = 7,
  parameter int LONG_MOD = 7,
  parameter bit DBL_EN   = 1'b1,
  parameter int P_W      = 4
) (
  input logic           clk_vco,
  input logic           clk_ref,
  input logic           rst_n,
  input logic [M_W-1:0] cfg_m,
  input logic           cfg_dbl,
  input logic [R_W-1:0] cfg_r,
  input logic           fb_pulse,
  input logic           fb_run,
  input logic           psc_tc,
  input logic [P_W-1:0] psc_cnt,
  input logic [M_W-1:0] mcnt,
  input logic           ref_pulse,
  input logic [R_W-1:0] ref_cnt
);

  AST_RESET_QUIET: assert property (@(posedge clk_vco) !rst_n |-> !fb_pulse && !ref_pulse); // R1

  AST_FB_ON_TC: assert property (@(posedge clk_vco) disable iff (!rst_n)
    fb_pulse |-> psc_tc); // R7

  AST_FB_SINGLE: assert property (@(posedge clk_vco) disable iff (!rst_n)
    fb_pulse |=> !fb_pulse); // R7

  AST_M_RELOAD: assert property (@(posedge clk_vco) disable iff (!rst_n)
    fb_pulse |=> mcnt == $past(cfg_m)); // R8

  AST_M_STEP: assert property (@(posedge clk_vco) disable iff (!rst_n)
    fb_run && psc_tc && !fb_pulse |=> mcnt == $past(mcnt) - 1'b1); // R2

  AST_M_HOLD: assert property (@(posedge clk_vco) disable iff (!rst_n)
    fb_run && !psc_tc |=> $stable(mcnt)); // R2

  AST_FIRST_LONG: assert property (@(posedge clk_vco) disable iff (!rst_n)
    fb_pulse |=> int'(psc_cnt) == ((DBL_EN && $past(cfg_dbl)) ? 2 * LONG_MOD : LONG_MOD) - 1); // R6

  AST_REF_SINGLE: assert property (@(posedge clk_ref) disable iff (!rst_n)
    ref_pulse && (cfg_r != '0) |=> !ref_pulse); // R9

  AST_REF_RELOAD: assert property (@(posedge clk_ref) disable iff (!rst_n)
    ref_pulse |=> ref_cnt == $past(cfg_r)); // R10

endmodule

bind fbdiv_top fbdiv_checker #(
  .M_W     (M_W),
  .R_W     (R_W),
  .LONG_MOD(LONG_MOD),
  .DBL_EN  (DBL_EN),
  .P_W     (P_W)
) u_chk (
  .clk_vco  (clk_vco),
  .clk_ref  (clk_ref),
  .rst_n    (rst_n),
  .cfg_m    (cfg_m),
  .cfg_dbl  (cfg_dbl),
  .cfg_r    (cfg_r),
  .fb_pulse (fb_pulse),
  .fb_run   (fb_run),
  .psc_tc   (psc_tc),
  .psc_cnt  (psc_cnt),
  .mcnt     (mcnt),
  .ref_pulse(ref_pulse),
  .ref_cnt  (ref_cnt)
);

// File: tb/fbdiv_top_tb_top.sv
`timescale 1ns/1ps
module fbdiv_top_tb_top;

  logic       clk_vco = 1'b0;
  logic       clk_ref = 1'b0;
  logic       rst_n   = 1'b0;
  logic [5:0] cfg_m   = 6'd0;
  logic [3:0] cfg_a   = 4'd0;
  logic       cfg_dbl = 1'b0;
  logic [6:0] cfg_r   = 7'd0;
  logic       fb_pulse;
  logic       ref_pulse;

  int checks = 0;
  int errors = 0;
  int vco_cycles = 0;

  always #2 clk_vco = ~clk_vco;  // 250 MHz
  always #5 clk_ref = ~clk_ref;

  fbdiv_top dut_i (
    .clk_vco  (clk_vco),
    .clk_ref  (clk_ref),
    .rst_n    (rst_n),
    .cfg_m    (cfg_m),
    .cfg_a    (cfg_a),
    .cfg_dbl  (cfg_dbl),
    .cfg_r    (cfg_r),
    .fb_pulse (fb_pulse),
    .ref_pulse(ref_pulse)
  );

  // Expected spacing: walk the prescaler periods of one frame.
  function automatic int exp_fb(int m, int a, bit dbl);
    int total = 0;
    for (int i = 0; i <= m; i++) begin
      if (a == 0 || i < a) total += 7;
      else total += 6;
    end
    if (dbl) total = total * 2;
    return total;
  endfunction

  function automatic string regime(int m, int a, bit dbl);
    string s;
    if (a == 0) s = "R3";
    else if (a <= m + 1) s = "R4";
    else s = "R5";
    if (dbl) s = {s, "/R6"};
    return s;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  task automatic wait_fb();
    do @(negedge clk_vco); while (!fb_pulse);
  endtask

  // Called at a negedge where fb_pulse is high; returns cycles to the next pulse.
  task automatic fb_gap(output int g, input string req);
    g = 0;
    do begin
      @(negedge clk_vco);
      g++;
      if (g == 1) check(!fb_pulse, {req, " R7 width"}, fb_pulse, 0);
    end while (!fb_pulse);
  endtask

  task automatic wait_ref();
    do @(negedge clk_ref); while (!ref_pulse);
  endtask

  task automatic ref_gap(output int g);
    g = 0;
    do begin
      @(negedge clk_ref);
      g++;
    end while (!ref_pulse);
  endtask

  task automatic fb_case(input int m, input int a, input bit dbl, input int frames);
    int g;
    string req;
    req = regime(m, a, dbl);
    wait_fb();
    cfg_m = 6'(m); cfg_a = 4'(a); cfg_dbl = dbl;
    for (int f = 0; f < frames; f++) begin
      fb_gap(g, req);
      check(g == exp_fb(m, a, dbl), {req, " R2 spacing"}, g, exp_fb(m, a, dbl));
    end
  endtask

  initial begin : watchdog
    forever begin
      @(posedge clk_vco);
      vco_cycles++;
      if (vco_cycles > 190000) begin
        checks++;
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", vco_cycles, 190000);
        finish_run();
      end
    end
  end

  initial begin : main
    int g;
    int rm, ra, rd, rr;
    void'($urandom(32'h00C0FFEE));

    // R1: quiet during reset
    for (int i = 0; i < 6; i++) begin
      @(negedge clk_vco);
      check(!fb_pulse && !ref_pulse, "R1 reset", {fb_pulse, ref_pulse}, 0);
    end
    cfg_m = 6'd2; cfg_a = 4'd0; cfg_r = 7'd4;
    @(negedge clk_vco);
    rst_n = 1'b1;

    // Directed corners
    fb_case(2, 0, 0, 2);    // R3: 21
    fb_case(0, 0, 0, 2);    // R3: 7
    fb_case(0, 1, 0, 1);    // R4: A = M+1 -> 7
    fb_case(0, 2, 0, 1);    // R5: A beyond frame -> 7
    fb_case(3, 4, 0, 1);    // R4: A = M+1 -> 28
    fb_case(5, 2, 0, 2);    // R4: 38
    fb_case(9, 15, 0, 1);   // R5: 70
    fb_case(5, 2, 1, 1);    // R6: 76
    fb_case(63, 0, 0, 1);   // R3: 448
    fb_case(63, 15, 1, 1);  // R4/R6: 798

    // R8: mid-frame change keeps the current frame
    fb_case(4, 3, 0, 1);
    @(negedge clk_vco);
    cfg_m = 6'd10; cfg_a = 4'd1; cfg_dbl = 1'b1;
    g = 1;
    while (!fb_pulse) begin @(negedge clk_vco); g++; end
    check(g == exp_fb(4, 3, 0), "R8 old frame kept", g, exp_fb(4, 3, 0));
    fb_gap(g, "R8");
    check(g == exp_fb(10, 1, 1), "R8 new frame", g, exp_fb(10, 1, 1));

    // Random sweep
    for (int it = 0; it < 30; it++) begin
      rm = $urandom_range(0, 63);
      ra = $urandom_range(0, 15);
      rd = $urandom_range(0, 1);
      fb_case(rm, ra, rd[0], 1);
    end

    // R9: reference divider
    wait_ref();
    cfg_r = 7'd9;
    ref_gap(g);
    check(g == 10, "R9 ref 9", g, 10);
    ref_gap(g);
    check(g == 10, "R9 ref 9 steady", g, 10);
    cfg_r = 7'd127;
    ref_gap(g);
    check(g == 128, "R9 ref 127", g, 128);
    // R10: mid-frame change keeps current frame
    @(negedge clk_ref);
    cfg_r = 7'd3;
    g = 1;
    while (!ref_pulse) begin @(negedge clk_ref); g++; end
    check(g == 128, "R10 old ref frame kept", g, 128);
    ref_gap(g);
    check(g == 4, "R10 new ref frame", g, 4);
    for (int it = 0; it < 6; it++) begin
      rr = $urandom_range(1, 127);
      cfg_r = 7'(rr);
      ref_gap(g);
      check(g == rr + 1, "R9 ref random", g, rr + 1);
    end
    // R9: zero field gives continuous high
    cfg_r = 7'd0;
    ref_gap(g);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk_ref);
      check(ref_pulse, "R9 ref zero high", ref_pulse, 1);
    end

    finish_run();
  end

endmodule